// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block terminates a chip-select framed serial link that uses a single bidirectional data wire. A host raises chip select, then clocks in a frame. Each data bit is taken on a rising edge of the serial clock. The payload comes first and a 3-bit mode code comes last. The block cannot tell how long a frame is until chip select drops. At that point it looks at the last three bits to find the command, checks that the bit count fits that command, and then acts on it. It can:

- write a segment pattern into one or all three grid latches,
- load a 10-bit dimming value,
- pulse a scan-stop or sleep request, or
- arm a switch-matrix readout.

An armed readout starts at the next rising edge of chip select. The block captures the 30 switch bits and turns the data wire into an output. It shifts one bit out per rising serial clock edge and releases the wire when chip select falls. The serial clock, chip select and data are brought into the core clock domain through synchronizers, and all edges are detected there.

Top module: `serial_cmd_decoder`

## Requirements
- R1: After reset, no latch strobe or command pulse is active, the data-wire output enable is low, and the segment and dimming outputs are zero.
- R2: A frame of exactly 85 bits with mode code 0 pulses all three grid strobes (`seg_wr_o` = 3'b111) once. Afterwards `seg_data_o[i]` equals the (i+1)-th bit sent. The mode code is {third-last, second-last, last} bit order reversed: mode = {m2,m1,m0}, with m0 sent first.
- R3: An 85-bit frame with mode code 1, 2 or 3 pulses only `seg_wr_o[mode-1]` and loads `seg_data_o` the same way as R2.
- R4: A 13-bit frame with mode code 4 pulses `dim_wr_o` once. `dim_data_o` then holds the ten payload bits, with the first bit sent as bit 0.
- R5: A 3-bit frame with mode code 5 pulses `scan_stop_o` once and nothing else.
- R6: A 3-bit frame with mode code 7 pulses `sleep_o` once. The next rising edge of chip select pulses `wake_o` once. A rising edge of chip select while not asleep gives no `wake_o`.
- R7: A frame whose bit count differs from the count its mode requires has no effect: no strobe and no pulse, no readout is armed, and `seg_data_o` and `dim_data_o` keep their values.
- R8: After a 3-bit frame with mode code 6, the data wire stays an input for the rest of that window. In the next window `sdio_oe_o` is high, and after the k-th rising serial clock edge `sdio_o` equals `keys_i[k-1]`, where `keys_i[(r-1)*6+(c-1)]` is row r, column c. `sdio_oe_o` drops when chip select falls.
- R9: Serial clock edges while chip select is low are not counted as frame bits.
- R10: Bits clocked during a readout window are never executed as a command. One arming opens only one readout window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, frame active while high |
| sclk_i | input | 1 | Serial clock from host |
| sdio_i | input | 1 | Data wire, input side |
| sdio_o | output | 1 | Data wire, output side |
| sdio_oe_o | output | 1 | Data wire output enable |
| keys_i | input | 30 | Switch matrix state, row-major, 6 columns per row |
| seg_data_o | output | 82 | Segment pattern for the grid latches |
| seg_wr_o | output | 3 | Grid latch write strobes, bit g for grid g+1 |
| dim_data_o | output | 10 | Dimming value |
| dim_wr_o | output | 1 | Dimming latch write strobe |
| scan_stop_o | output | 1 | Scan-stop command pulse |
| sleep_o | output | 1 | Sleep command pulse |
| wake_o | output | 1 | Wake pulse on chip-select rise while asleep |

## Verification
A bit counter or shift register that has slipped shows up within three core cycles of the chip-select fall. The symptom is a missing or wrong strobe, or a segment or dimming value that is moved by one position. A stale armed flag or a stale readout flag shows at the next chip-select rise: the output enable is wrong there, or the serial bits come out in the wrong order or misaligned. A sleep flag that stays stuck gives an extra or missing wake pulse at the very next window.

// File: rtl/scfd_pkg.sv
package scfd_pkg;
    localparam int SEG_W   = 82;
    localparam int DIM_W   = 10;
    localparam int MODE_W  = 3;
    localparam int KEY_W   = 30;
    localparam int GRID_N  = 3;
    localparam int SEG_LEN = SEG_W + MODE_W;
    localparam int DIM_LEN = DIM_W + MODE_W;
    localparam int CNT_W   = $clog2(SEG_LEN + 2);

    typedef enum logic [MODE_W-1:0] {
        M_SEG_ALL   = 3'd0,
        M_SEG_G1    = 3'd1,
        M_SEG_G2    = 3'd2,
        M_SEG_G3    = 3'd3,
        M_DIM       = 3'd4,
        M_SCAN_STOP = 3'd5,
        M_KEY_READ  = 3'd6,
        M_SLEEP     = 3'd7
    } mode_e;
endpackage

// File: rtl/scfd_sync.sv
module scfd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) chain_d[k] = chain_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= chain_d[k];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scfd_rx_shift.sv
module scfd_rx_shift #(
    parameter int FRAME_W = 85,
    parameter int CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               shift_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   count_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   cnt;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (clr_i) begin
            rx_d = '0;
        end else if (shift_i) begin
            // newest bit enters at index 0; the mode code ends in [2:0]
            rx_d.frame = {rx_q.frame[FRAME_W-2:0], bit_i};
            if (rx_q.cnt != {CNT_W{1'b1}}) rx_d.cnt = rx_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign frame_o = rx_q.frame;
    assign count_o = rx_q.cnt;
endmodule

// File: rtl/scfd_decode.sv
module scfd_decode
    import scfd_pkg::*;
#(
    parameter int SEG_BITS = SEG_W,
    parameter int DIM_BITS = DIM_W,
    parameter int CW       = CNT_W,
    localparam int FRAME_W = SEG_BITS + MODE_W
) (
    input  logic [FRAME_W-1:0]  frame_i,
    input  logic [CW-1:0]       count_i,
    output logic [MODE_W-1:0]   mode_o,
    output logic                valid_o,
    output logic [SEG_BITS-1:0] seg_o,
    output logic [DIM_BITS-1:0] dim_o
);
    localparam int LEN_SEG = SEG_BITS + MODE_W;
    localparam int LEN_DIM = DIM_BITS + MODE_W;

    // m0 arrives first of the three, so it sits deepest: mode[j] = frame[MODE_W-1-j]
    for (genvar j = 0; j < MODE_W; j++) begin : g_mode
        assign mode_o[j] = frame_i[MODE_W-1-j];
    end

    // first payload bit sent is the oldest one in the register
    for (genvar i = 0; i < SEG_BITS; i++) begin : g_seg
        assign seg_o[i] = frame_i[MODE_W + SEG_BITS - 1 - i];
    end

    for (genvar i = 0; i < DIM_BITS; i++) begin : g_dim
        assign dim_o[i] = frame_i[MODE_W + DIM_BITS - 1 - i];
    end

    logic [CW-1:0] need;
    always_comb begin
        if (mode_o <= M_SEG_G3)      need = CW'(LEN_SEG);
        else if (mode_o == M_DIM)    need = CW'(LEN_DIM);
        else                         need = CW'(MODE_W);
        valid_o = (count_i == need);  // R7 length check
    end
endmodule

// File: rtl/scfd_tx_shift.sv
module scfd_tx_shift #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         shift_i,
    output logic         bit_o
);
    typedef struct packed {
        logic [W-1:0] sr;
        logic         out;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (load_i) begin
            tx_d.sr  = val_i;
            tx_d.out = 1'b0;
        end else if (shift_i) begin
            tx_d.out = tx_q.sr[0];
            tx_d.sr  = {1'b0, tx_q.sr[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign bit_o = tx_q.out;
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
    import scfd_pkg::*;
#(
    parameter int SEG_BITS  = SEG_W,
    parameter int DIM_BITS  = DIM_W,
    parameter int KEY_BITS  = KEY_W,
    parameter int GRIDS     = GRID_N,
    parameter int SYNC_STG  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_i,
    input  logic                sclk_i,
    input  logic                sdio_i,
    output logic                sdio_o,
    output logic                sdio_oe_o,
    input  logic [KEY_BITS-1:0] keys_i,
    output logic [SEG_BITS-1:0] seg_data_o,
    output logic [GRIDS-1:0]    seg_wr_o,
    output logic [DIM_BITS-1:0] dim_data_o,
    output logic                dim_wr_o,
    output logic                scan_stop_o,
    output logic                sleep_o,
    output logic                wake_o
);
    localparam int FRAME_W = SEG_BITS + MODE_W;
    localparam int CW      = $clog2(FRAME_W + 2);

    typedef struct packed {
        logic                cs_prev;
        logic                sclk_prev;
        logic                armed;
        logic                readout;
        logic                asleep;
        logic                oe;
        logic                dim_wr;
        logic                scan_stop;
        logic                sleep;
        logic                wake;
        logic [GRIDS-1:0]    seg_wr;
        logic [SEG_BITS-1:0] seg;
        logic [DIM_BITS-1:0] dim;
    } core_t;

    core_t c_d, c_q;

    logic [2:0]          pins_s;
    logic                cs_s, sclk_s, data_s;
    logic                cs_rise, cs_fall, sclk_rise;
    logic [FRAME_W-1:0]  frame;
    logic [CW-1:0]       count;
    logic [MODE_W-1:0]   mode;
    logic                frame_ok;
    logic [SEG_BITS-1:0] seg_pay;
    logic [DIM_BITS-1:0] dim_pay;

    scfd_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_i, sclk_i, sdio_i}),
        .q_o   (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign data_s = pins_s[0];

    assign cs_rise   = cs_s & ~c_q.cs_prev;
    assign cs_fall   = ~cs_s & c_q.cs_prev;
    // R9: a serial clock edge counts only inside a chip-select window
    assign sclk_rise = sclk_s & ~c_q.sclk_prev & cs_s;

    scfd_rx_shift #(.FRAME_W(FRAME_W), .CNT_W(CW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cs_rise),
        .shift_i (sclk_rise & ~c_q.readout),
        .bit_i   (data_s),
        .frame_o (frame),
        .count_o (count)
    );

    scfd_decode #(.SEG_BITS(SEG_BITS), .DIM_BITS(DIM_BITS), .CW(CW)) u_dec (
        .frame_i (frame),
        .count_i (count),
        .mode_o  (mode),
        .valid_o (frame_ok),
        .seg_o   (seg_pay),
        .dim_o   (dim_pay)
    );

    scfd_tx_shift #(.W(KEY_BITS)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cs_rise & c_q.armed),
        .val_i   (keys_i),
        .shift_i (sclk_rise & c_q.readout),
        .bit_o   (sdio_o)
    );

    always_comb begin
        c_d           = c_q;
        c_d.cs_prev   = cs_s;
        c_d.sclk_prev = sclk_s;
        c_d.seg_wr    = '0;
        c_d.dim_wr    = 1'b0;
        c_d.scan_stop = 1'b0;
        c_d.sleep     = 1'b0;
        c_d.wake      = 1'b0;

        if (cs_rise) begin
            if (c_q.asleep) begin          // R6 wake on window start
                c_d.wake   = 1'b1;
                c_d.asleep = 1'b0;
            end
            if (c_q.armed) begin           // R8 readout window opens
                c_d.readout = 1'b1;
                c_d.oe      = 1'b1;
                c_d.armed   = 1'b0;        // R10 single use
            end
        end

        if (cs_fall) begin
            c_d.oe      = 1'b0;
            c_d.readout = 1'b0;
            if (!c_q.readout && frame_ok) begin   // R10, R7
                case (mode)
                    M_SEG_ALL: begin
                        c_d.seg_wr = '1;
                        c_d.seg    = seg_pay;
                    end
                    M_SEG_G1, M_SEG_G2, M_SEG_G3: begin
                        for (int g = 0; g < GRIDS; g++)
                            if (mode == MODE_W'(g + 1)) c_d.seg_wr[g] = 1'b1;
                        c_d.seg = seg_pay;
                    end
                    M_DIM: begin
                        c_d.dim_wr = 1'b1;
                        c_d.dim    = dim_pay;
                    end
                    M_SCAN_STOP: c_d.scan_stop = 1'b1;
                    M_KEY_READ:  c_d.armed     = 1'b1;
                    default: begin
                        c_d.sleep  = 1'b1;
                        c_d.asleep = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sdio_oe_o   = c_q.oe;
    assign seg_data_o  = c_q.seg;
    assign seg_wr_o    = c_q.seg_wr;
    assign dim_data_o  = c_q.dim;
    assign dim_wr_o    = c_q.dim_wr;
    assign scan_stop_o = c_q.scan_stop;
    assign sleep_o     = c_q.sleep;
    assign wake_o      = c_q.wake;
endmodule

// File: rtl/scfd_checker.sv
module scfd_checker
    import scfd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_i,
    input logic              sdio_oe_o,
    input logic [SEG_W-1:0]  seg_data_o,
    input logic [GRID_N-1:0] seg_wr_o,
    input logic [DIM_W-1:0]  dim_data_o,
    input logic              dim_wr_o,
    input logic              scan_stop_o,
    input logic              sleep_o,
    input logic              wake_o
);
    AST_GRID_STROBE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(seg_wr_o) || (&seg_wr_o))); // R3

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_wr_o == '0) |-> $stable(seg_data_o)); // R7

    AST_DIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dim_wr_o |-> $stable(dim_data_o)); // R7

    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({|seg_wr_o, dim_wr_o, scan_stop_o, sleep_o}) <= 1); // R5

    AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_i && $past(!cs_i) && $past(!cs_i, 2) && $past(!cs_i, 3)) |-> !sdio_oe_o); // R8

    AST_WAKE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ({seg_wr_o, dim_wr_o, scan_stop_o, sleep_o} == '0)); // R6
endmodule

bind serial_cmd_decoder scfd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_i        (cs_i),
    .sdio_oe_o   (sdio_oe_o),
    .seg_data_o  (seg_data_o),
    .seg_wr_o    (seg_wr_o),
    .dim_data_o  (dim_data_o),
    .dim_wr_o    (dim_wr_o),
    .scan_stop_o (scan_stop_o),
    .sleep_o     (sleep_o),
    .wake_o      (wake_o)
);

// File: tb/tb_serial_cmd_decoder.sv
module tb_serial_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_i = 1'b0, sclk_i = 1'b0, sdio_i = 1'b0;
    logic        sdio_o, sdio_oe_o;
    logic [29:0] keys_i = 30'h2A5F0C39;
    logic [81:0] seg_data_o;
    logic [2:0]  seg_wr_o;
    logic [9:0]  dim_data_o;
    logic        dim_wr_o, scan_stop_o, sleep_o, wake_o;

    int checks = 0, errors = 0;
    int n_grid [3];
    int n_dim = 0, n_stop = 0, n_sleep = 0, n_wake = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .keys_i(keys_i),
        .seg_data_o(seg_data_o), .seg_wr_o(seg_wr_o), .dim_data_o(dim_data_o),
        .dim_wr_o(dim_wr_o), .scan_stop_o(scan_stop_o), .sleep_o(sleep_o), .wake_o(wake_o)
    );

    initial begin
        for (int g = 0; g < 3; g++) n_grid[g] = 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            for (int g = 0; g < 3; g++) if (seg_wr_o[g]) n_grid[g]++;
            if (dim_wr_o)    n_dim++;
            if (scan_stop_o) n_stop++;
            if (sleep_o)     n_sleep++;
            if (wake_o)      n_wake++;
        end
    end

    typedef struct packed {
        logic [2:0]  mode;
        logic [7:0]  len;
        logic [31:0] seed;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 8'd85, 32'hA5C31E97},
        '{3'd1, 8'd85, 32'h3C0FF0A1},
        '{3'd2, 8'd85, 32'h9E3779B9},
        '{3'd3, 8'd85, 32'h12345678},
        '{3'd4, 8'd13, 32'h0000035B},
        '{3'd5, 8'd3,  32'h00000000},
        '{3'd7, 8'd3,  32'h00000000},
        '{3'd2, 8'd84, 32'hDEADBEEF},
        '{3'd4, 8'd85, 32'h0F0F00FF},
        '{3'd5, 8'd13, 32'h55AA55AA},
        '{3'd0, 8'd86, 32'hC001D00D}
    };

    function automatic logic pbit(logic [31:0] seed, int i);
        return seed[i % 32] ^ ((i / 7) % 2 == 1);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        sdio_i = b;
        idle(4);
        sclk_i = 1'b1;
        idle(4);
        sclk_i = 1'b0;
    endtask

    task automatic send(input logic [2:0] m, input int len, input logic [31:0] seed);
        cs_i = 1'b1;
        idle(6);
        for (int i = 0; i < len - 3; i++) sbit(pbit(seed, i));
        sbit(m[0]);
        sbit(m[1]);
        sbit(m[2]);
        idle(2);
        cs_i = 1'b0;
        idle(10);
    endtask

    function automatic string req_of(logic [2:0] m, bit ok);
        if (!ok)         return "R7";
        if (m == 3'd0)   return "R2";
        if (m <= 3'd3)   return "R3";
        if (m == 3'd4)   return "R4";
        if (m == 3'd5)   return "R5";
        return "R6";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [81:0] seg_prev, seg_exp;
        logic [9:0]  dim_prev, dim_exp;
        logic [29:0] got;
        int g0, g1, g2, d0, s0, z0, w0;

        idle(5);
        // R1 reset state, held during reset
        check("R1", "oe in reset", 128'(sdio_oe_o), 128'(0));
        rst_n = 1'b1;
        idle(5);
        check("R1", "strobes after reset", 128'({seg_wr_o, dim_wr_o, scan_stop_o, sleep_o, wake_o}), 128'(0));
        check("R1", "seg and dim after reset", 128'({seg_data_o, dim_data_o}), 128'(0));
        check("R1", "oe after reset", 128'(sdio_oe_o), 128'(0));

        // table of frames
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] m;
            int need, len;
            bit ok;
            m = VEC[v].mode;
            len = int'(VEC[v].len);
            need = (m <= 3'd3) ? 85 : (m == 3'd4) ? 13 : 3;
            ok = (len == need);
            g0 = n_grid[0]; g1 = n_grid[1]; g2 = n_grid[2];
            d0 = n_dim; s0 = n_stop; z0 = n_sleep;
            seg_prev = seg_data_o;
            dim_prev = dim_data_o;
            send(m, len, VEC[v].seed);
            for (int i = 0; i < 82; i++) seg_exp[i] = pbit(VEC[v].seed, i);
            for (int i = 0; i < 10; i++) dim_exp[i] = pbit(VEC[v].seed, i);
            check(req_of(m, ok), $sformatf("grid strobes vec%0d", v),
                  128'({8'(n_grid[2] - g2), 8'(n_grid[1] - g1), 8'(n_grid[0] - g0)}),
                  128'({8'(ok && (m == 0 || m == 3)), 8'(ok && (m == 0 || m == 2)),
                        8'(ok && (m == 0 || m == 1))}));
            check(req_of(m, ok), $sformatf("dim/stop/sleep pulses vec%0d", v),
                  128'({8'(n_dim - d0), 8'(n_stop - s0), 8'(n_sleep - z0)}),
                  128'({8'(ok && m == 4), 8'(ok && m == 5), 8'(ok && m == 7)}));
            check(req_of(m, ok), $sformatf("seg data vec%0d", v),
                  128'(seg_data_o), 128'((ok && m <= 3'd3) ? seg_exp : seg_prev));
            check(req_of(m, ok), $sformatf("dim data vec%0d", v),
                  128'(dim_data_o), 128'((ok && m == 3'd4) ? dim_exp : dim_prev));
        end

        // R6: sleep then wake on chip-select rise; second rise gives no wake
        send(3'd7, 3, 32'h0);
        w0 = n_wake;
        cs_i = 1'b1; idle(8);
        check("R6", "wake after sleep", 128'(n_wake - w0), 128'(1));
        cs_i = 1'b0; idle(8);
        cs_i = 1'b1; idle(8);
        check("R6", "no wake when awake", 128'(n_wake - w0), 128'(1));
        cs_i = 1'b0; idle(8);

        // R9: serial clocks while chip select is low are ignored
        for (int i = 0; i < 10; i++) begin
            sdio_i = 1'b1; idle(2); sclk_i = 1'b1; idle(2); sclk_i = 1'b0;
        end
        d0 = n_dim;
        send(3'd4, 13, 32'h000002C6);
        for (int i = 0; i < 10; i++) dim_exp[i] = pbit(32'h000002C6, i);
        check("R9", "dim pulse after idle clocks", 128'(n_dim - d0), 128'(1));
        check("R9", "dim value after idle clocks", 128'(dim_data_o), 128'(dim_exp));

        // R8: arm readout, data wire stays input in arming window
        send(3'd6, 3, 32'h0);
        check("R8", "oe after arming frame", 128'(sdio_oe_o), 128'(0));
        g0 = n_grid[0] + n_grid[1] + n_grid[2];
        d0 = n_dim; s0 = n_stop; z0 = n_sleep;
        cs_i = 1'b1; idle(8);
        check("R8", "oe in readout window", 128'(sdio_oe_o), 128'(1));
        for (int k = 0; k < 30; k++) begin
            sdio_i = k[0];
            idle(4);
            sclk_i = 1'b1;
            idle(4);
            got[k] = sdio_o;
            sclk_i = 1'b0;
        end
        check("R8", "switch bits order", 128'(got), 128'(keys_i));
        idle(2);
        cs_i = 1'b0; idle(10);
        check("R8", "oe released at cs fall", 128'(sdio_oe_o), 128'(0));

        // R10: a valid stop code clocked during a readout window is not executed
        send(3'd6, 3, 32'h0);
        cs_i = 1'b1; idle(8);
        sbit(1'b1); sbit(1'b0); sbit(1'b1);
        idle(2);
        cs_i = 1'b0; idle(10);
        check("R10", "no command from readout windows",
              128'({8'(n_grid[0] + n_grid[1] + n_grid[2] - g0), 8'(n_dim - d0),
                    8'(n_stop - s0), 8'(n_sleep - z0)}), 128'(0));
        cs_i = 1'b1; idle(8);
        check("R10", "arming consumed once", 128'(sdio_oe_o), 128'(0));
        cs_i = 1'b0; idle(8);

        // R7: readout request of wrong length does not arm
        send(3'd6, 5, 32'h00000007);
        cs_i = 1'b1; idle(8);
        check("R7", "no readout after bad-length request", 128'(sdio_oe_o), 128'(0));
        cs_i = 1'b0; idle(8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule